// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block models one macrocell of a programmable-logic device. A sum-of-products term arrives on `logicA`, with a second term on `logicB`, and a set of configuration inputs decides what the cell does with them. The cell can pass the term straight through as combinational logic. It can store it in an edge-triggered register. It can also hold it in a level-sensitive latch.

In front of the single D storage bit, a feed stage rewrites the next-state value. This lets the same bit behave as a D, toggle (T), J-K or set/reset (S-R) flip-flop. A polarity bit can invert the primary term before it reaches the storage.

Each cell picks one of four shared clock-enable lines. It also picks one set line and one reset line from three shared set/reset lines. The whole block runs on one system clock: the selected "clock" is a qualified enable sampled on that clock's rising edge.

In input-register mode, the cell ignores its logic terms and its mode field. It registers the value on a neighbouring pin (`padIn`) instead.

Top module: `plmc_cell`

## Requirements
- R1: While `rst_n` is low, the stored bit is 0, and in any registered mode (including input-register mode) `cellOut` is 0.
- R2: `modeSel` 0 selects combinational mode, in which `cellOut` equals `logicA ^ invertIn` in the same cycle. The unused codes 6 and 7 behave exactly like 0.
- R3: `modeSel` 1 is a D register: on a clock edge where the selected enable is high, the stored bit takes `logicA ^ invertIn`, and `cellOut` shows the stored bit.
- R4: `modeSel` 2 is a toggle register: on an enabled edge the stored bit becomes `q ^ (logicA ^ invertIn)`.
- R5: `modeSel` 3 is a J-K register, with J = `logicA ^ invertIn` and K = `logicB`. On an enabled edge the next bit is `(J & ~q) | (~K & q)`.
- R6: `modeSel` 4 is an S-R register, with S = `logicA ^ invertIn` and R = `logicB`. On an enabled edge S high gives 1 (even when R is also high), R alone gives 0, and neither holds.
- R7: `modeSel` 5 is a latch. While the selected enable is high, `cellOut` follows `logicA ^ invertIn` in the same cycle and the stored bit captures it at the edge. While the enable is low, `cellOut` shows the held bit.
- R8: `invertIn` = 1 inverts the primary term ahead of the storage element in every mode that uses it.
- R9: Only clock-enable line `clkLines[clkSel]` gates storage updates. A high level on any other line leaves the stored bit unchanged.
- R10: `rstSel` and `setSel` (0 to 2) each choose a line of `srLines`; the value 3 chooses none. A chosen line that is high forces the stored bit to 0 (reset) or 1 (set) at the next edge without needing the clock enable. Reset wins when both are active.
- R11: With `padMode` = 1, the cell acts as a D register of `padIn` regardless of `modeSel`, `logicA`, `logicB` and `invertIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| logicA | input | 1 | Primary sum-of-products term (D, T, J or S) |
| logicB | input | 1 | Secondary term (K or R) |
| invertIn | input | 1 | Polarity control for the primary term |
| padIn | input | 1 | Neighbouring pin value used in input-register mode |
| padMode | input | 1 | Input-register mode enable |
| modeSel | input | 3 | Storage mode code (0 comb, 1 D, 2 T, 3 JK, 4 SR, 5 latch) |
| clkLines | input | 4 | Shared clock-enable lines |
| clkSel | input | 2 | Clock-enable line select |
| srLines | input | 3 | Shared set/reset lines, active high |
| setSel | input | 2 | Set line select, 3 = none |
| rstSel | input | 2 | Reset line select, 3 = none |
| cellOut | output | 1 | Macrocell output |

## Verification
A wrong stored bit shows on `cellOut` one cycle after the edge that produced it, in every registered mode. In latch mode it shows in the first cycle the enable is low. In combinational mode the stored bit is masked, so an error there only appears once the mode changes.

A wrong line select or wrong feed decode shows at the very next enabled edge, as a bit that differs from the next-state rule. Toggle and J-K sequences run over several edges, so a decode slip compounds and stays visible on every later cycle.

// File: rtl/plmc_pkg.sv
package plmc_pkg;

  typedef enum logic [2:0] {
    K_COMB  = 3'd0,
    K_D     = 3'd1,
    K_T     = 3'd2,
    K_JK    = 3'd3,
    K_SR    = 3'd4,
    K_LATCH = 3'd5
  } kind_e;

  typedef struct packed {
    logic  capture;      // selected enable high and kind stores
    logic  transparent;  // latch open this cycle
    logic  forceSet;
    logic  forceClr;
    logic  padSrc;       // data comes from neighbouring pin
    kind_e kind;
  } ctrlStrobe_t;

endpackage

// File: rtl/plmc_ctrl.sv
module plmc_ctrl
  import plmc_pkg::*;
#(
  parameter int NUM_CLK   = 4,
  parameter int NUM_SR    = 3,
  parameter int CLK_SEL_W = 2,
  parameter int SR_SEL_W  = 2
) (
  input  logic                 padMode,
  input  logic [2:0]           modeSel,
  input  logic [NUM_CLK-1:0]   clkLines,
  input  logic [CLK_SEL_W-1:0] clkSel,
  input  logic [NUM_SR-1:0]    srLines,
  input  logic [SR_SEL_W-1:0]  setSel,
  input  logic [SR_SEL_W-1:0]  rstSel,
  output ctrlStrobe_t          strobe
);

  logic [NUM_SR-1:0] setVec;
  logic [NUM_SR-1:0] clrVec;
  logic              selEn;
  kind_e             kind;

  genvar g;
  generate
    for (g = 0; g < NUM_SR; g++) begin : g_srLine
      assign setVec[g] = srLines[g] & (setSel == SR_SEL_W'(g));
      assign clrVec[g] = srLines[g] & (rstSel == SR_SEL_W'(g));
    end
  endgenerate

  always_comb begin
    selEn = 1'b0;
    for (int i = 0; i < NUM_CLK; i++) begin
      if (clkSel == CLK_SEL_W'(i)) selEn = clkLines[i];
    end
  end

  always_comb begin
    if (padMode) begin
      kind = K_D;
    end else begin
      case (modeSel)
        3'd1:    kind = K_D;
        3'd2:    kind = K_T;
        3'd3:    kind = K_JK;
        3'd4:    kind = K_SR;
        3'd5:    kind = K_LATCH;
        default: kind = K_COMB;
      endcase
    end
  end

  always_comb begin
    strobe.kind        = kind;
    strobe.padSrc      = padMode;
    strobe.forceSet    = |setVec;
    strobe.forceClr    = |clrVec;
    strobe.transparent = selEn & (kind == K_LATCH);
    strobe.capture     = selEn & (kind != K_COMB);
  end

endmodule

// File: rtl/plmc_datapath.sv
module plmc_datapath
  import plmc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        logicA,
  input  logic        logicB,
  input  logic        invertIn,
  input  logic        padIn,
  input  ctrlStrobe_t strobe,
  output logic        qNow,
  output logic        cellOut
);

  logic termA;
  logic srcBit;
  logic nextD;
  logic qReg;

  assign termA  = logicA ^ invertIn;
  assign srcBit = strobe.padSrc ? padIn : termA;

  // feed stage in front of the single D bit
  always_comb begin
    case (strobe.kind)
      K_D:     nextD = srcBit;
      K_T:     nextD = qReg ^ srcBit;
      K_JK:    nextD = (srcBit & ~qReg) | (~logicB & qReg);
      K_SR:    nextD = srcBit ? 1'b1 : (logicB ? 1'b0 : qReg);
      K_LATCH: nextD = srcBit;
      default: nextD = qReg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                qReg <= 1'b0;
    else if (strobe.forceClr)  qReg <= 1'b0;
    else if (strobe.forceSet)  qReg <= 1'b1;
    else if (strobe.capture)   qReg <= nextD;
  end

  always_comb begin
    case (strobe.kind)
      K_COMB:  cellOut = termA;
      K_LATCH: cellOut = strobe.transparent ? srcBit : qReg;
      default: cellOut = qReg;
    endcase
  end

  assign qNow = qReg;

endmodule

// File: rtl/plmc_cell.sv
module plmc_cell
  import plmc_pkg::*;
#(
  parameter int NUM_CLK = 4,
  parameter int NUM_SR  = 3,
  localparam int CLK_SEL_W = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1,
  localparam int SR_SEL_W  = $clog2(NUM_SR + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 logicA,
  input  logic                 logicB,
  input  logic                 invertIn,
  input  logic                 padIn,
  input  logic                 padMode,
  input  logic [2:0]           modeSel,
  input  logic [NUM_CLK-1:0]   clkLines,
  input  logic [CLK_SEL_W-1:0] clkSel,
  input  logic [NUM_SR-1:0]    srLines,
  input  logic [SR_SEL_W-1:0]  setSel,
  input  logic [SR_SEL_W-1:0]  rstSel,
  output logic                 cellOut
);

  ctrlStrobe_t strobe;
  logic        qNow;

  plmc_ctrl #(
    .NUM_CLK  (NUM_CLK),
    .NUM_SR   (NUM_SR),
    .CLK_SEL_W(CLK_SEL_W),
    .SR_SEL_W (SR_SEL_W)
  ) u_ctrl (
    .padMode (padMode),
    .modeSel (modeSel),
    .clkLines(clkLines),
    .clkSel  (clkSel),
    .srLines (srLines),
    .setSel  (setSel),
    .rstSel  (rstSel),
    .strobe  (strobe)
  );

  plmc_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .logicA  (logicA),
    .logicB  (logicB),
    .invertIn(invertIn),
    .padIn   (padIn),
    .strobe  (strobe),
    .qNow    (qNow),
    .cellOut (cellOut)
  );

endmodule

// File: rtl/plmc_cell_chk.sv
module plmc_cell_chk #(
  parameter int NUM_CLK   = 4,
  parameter int NUM_SR    = 3,
  parameter int CLK_SEL_W = 2,
  parameter int SR_SEL_W  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 logicA,
  input logic                 logicB,
  input logic                 invertIn,
  input logic                 padIn,
  input logic                 padMode,
  input logic [2:0]           modeSel,
  input logic [NUM_CLK-1:0]   clkLines,
  input logic [CLK_SEL_W-1:0] clkSel,
  input logic [NUM_SR-1:0]    srLines,
  input logic [SR_SEL_W-1:0]  setSel,
  input logic [SR_SEL_W-1:0]  rstSel,
  input logic                 cellOut,
  input logic                 qNow
);

  logic enSeen;
  logic clrSeen;
  logic setSeen;
  logic quiet;
  logic termA;

  always_comb begin
    enSeen  = 1'b0;
    clrSeen = 1'b0;
    setSeen = 1'b0;
    for (int i = 0; i < NUM_CLK; i++)
      if (int'(clkSel) == i) enSeen = clkLines[i];
    for (int i = 0; i < NUM_SR; i++) begin
      if (int'(rstSel) == i) clrSeen = srLines[i];
      if (int'(setSel) == i) setSeen = srLines[i];
    end
  end

  assign quiet = !clrSeen && !setSeen;
  assign termA = logicA ^ invertIn;

  // R10
  clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clrSeen |=> (qNow == 1'b0));

  // R10
  set_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setSeen && !clrSeen) |=> (qNow == 1'b1));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !enSeen) |=> $stable(qNow));

  // R2
  comb_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!padMode && (modeSel == 3'd0 || modeSel > 3'd5)) |-> (cellOut == termA));

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!padMode && modeSel == 3'd2 && enSeen && quiet && termA) |=> (qNow != $past(qNow)));

  // R5
  jk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!padMode && modeSel == 3'd3 && enSeen && quiet && termA && !logicB) |=> qNow);

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!padMode && modeSel == 3'd5 && !enSeen) |-> (cellOut == qNow));

  // R11
  pad_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (padMode && enSeen && quiet) |=> (qNow == $past(padIn)));

endmodule

bind plmc_cell plmc_cell_chk #(
  .NUM_CLK  (NUM_CLK),
  .NUM_SR   (NUM_SR),
  .CLK_SEL_W(CLK_SEL_W),
  .SR_SEL_W (SR_SEL_W)
) u_chk (.*);

// File: tb/plmc_cell_bench.sv
`timescale 1ns/1ps
module plmc_cell_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       logicA = 1'b0, logicB = 1'b0, invertIn = 1'b0, padIn = 1'b0, padMode = 1'b0;
  logic [2:0] modeSel = 3'd1;
  logic [3:0] clkLines = 4'd0;
  logic [1:0] clkSel = 2'd0;
  logic [2:0] srLines = 3'd0;
  logic [1:0] setSel = 2'd3, rstSel = 2'd3;
  logic       cellOut;

  int checks = 0;
  int errors = 0;
  bit qm = 1'b0;

  always #5 clk = ~clk;

  plmc_cell u_plmc_cell (
    .clk(clk), .rst_n(rst_n), .logicA(logicA), .logicB(logicB),
    .invertIn(invertIn), .padIn(padIn), .padMode(padMode), .modeSel(modeSel),
    .clkLines(clkLines), .clkSel(clkSel), .srLines(srLines),
    .setSel(setSel), .rstSel(rstSel), .cellOut(cellOut)
  );

  function automatic int kindOf();
    if (padMode) return 1;
    if (modeSel >= 3'd1 && modeSel <= 3'd5) return int'(modeSel);
    return 0;
  endfunction

  function automatic bit enNow();
    return clkLines[clkSel];
  endfunction

  function automatic bit lineHit(logic [1:0] sel);
    return (sel < 2'd3) ? srLines[sel] : 1'b0;
  endfunction

  function automatic bit srcNow();
    return padMode ? padIn : (logicA ^ invertIn);
  endfunction

  function automatic bit expOut();
    case (kindOf())
      0: return logicA ^ invertIn;
      5: return enNow() ? srcNow() : qm;
      default: return qm;
    endcase
  endfunction

  function automatic bit expNext();
    bit s;
    s = srcNow();
    if (lineHit(rstSel)) return 1'b0;
    if (lineHit(setSel)) return 1'b1;
    if (!enNow()) return qm;
    case (kindOf())
      1, 5: return s;
      2: return qm ^ s;
      3: return (s & ~qm) | (~logicB & qm);
      4: return s ? 1'b1 : (logicB ? 1'b0 : qm);
      default: return qm;
    endcase
  endfunction

  function automatic string tagOf();
    if (lineHit(rstSel) || lineHit(setSel)) return "R10";
    case (kindOf())
      0: return "R2";
      1: return padMode ? "R11" : "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: cellOut=%0b expected %0b", tag, $time, got, exp);
    end
  endtask

  // inputs were driven after a negedge; check, then advance the model at posedge
  task automatic stepCheck(input string tag);
    #1;
    check(cellOut, expOut(), (tag == "") ? tagOf() : tag);
    @(posedge clk);
    qm = expNext();
    @(negedge clk);
  endtask

  task automatic setCfg(input bit pm, input logic [2:0] m, input bit inv);
    padMode = pm; modeSel = m; invertIn = inv;
    srLines = 3'd0; setSel = 2'd3; rstSel = 2'd3;
    clkSel = 2'd1; clkLines = 4'd0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: expired, expected run to finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, registered mode and input-register mode
    modeSel = 3'd1; clkLines = 4'hF; logicA = 1'b1;
    #1 check(cellOut, 1'b0, "R1");
    padMode = 1'b1; padIn = 1'b1;
    #1 check(cellOut, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1; qm = 1'b0;

    // R3 + R8: D register captures inverted term on selected line
    setCfg(0, 3'd1, 1); logicA = 1'b0; clkLines = 4'b0010;
    stepCheck("R8");
    stepCheck("R3");                // shows 1 from inverted 0
    // R9: other lines high, selected low: hold
    logicA = 1'b1; clkLines = 4'b1101;
    stepCheck("R9");
    stepCheck("R9");

    // R4: toggle sequence
    setCfg(0, 3'd2, 0); logicA = 1'b1; clkLines = 4'b0010;
    for (int i = 0; i < 4; i++) stepCheck("R4");

    // R5: JK toggle (J=K=1), then hold
    setCfg(0, 3'd3, 0); logicA = 1'b1; logicB = 1'b1; clkLines = 4'b0010;
    for (int i = 0; i < 3; i++) stepCheck("R5");
    logicA = 1'b0; logicB = 1'b0;
    stepCheck("R5");

    // R6: S and R both high -> set
    setCfg(0, 3'd4, 0); logicA = 1'b1; logicB = 1'b1; clkLines = 4'b0010;
    stepCheck("R6"); stepCheck("R6");
    logicA = 1'b0;
    stepCheck("R6"); stepCheck("R6");

    // R7: latch transparency then hold
    setCfg(0, 3'd5, 0); logicA = 1'b1; clkLines = 4'b0010;
    stepCheck("R7");
    clkLines = 4'b0000; logicA = 1'b0;
    stepCheck("R7"); stepCheck("R7");

    // R2: unused code 7 acts combinational
    setCfg(0, 3'd7, 1); logicA = 1'b0;
    stepCheck("R2");
    modeSel = 3'd6; logicA = 1'b1;
    stepCheck("R2");

    // R10: reset priority without enable, then set alone
    setCfg(0, 3'd1, 0); srLines = 3'b101; setSel = 2'd0; rstSel = 2'd2;
    stepCheck("R10"); stepCheck("R10");
    rstSel = 2'd3;
    stepCheck("R10"); stepCheck("R10");
    srLines = 3'b000;

    // R11: pad data ignores logic terms and mode
    setCfg(1, 3'd0, 1); logicA = 1'b1; padIn = 1'b0; clkLines = 4'b0010;
    stepCheck("R11"); stepCheck("R11");
    padIn = 1'b1; logicA = 1'b0;
    stepCheck("R11"); stepCheck("R11");

    // constrained random
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      logicA   = 1'($urandom);
      logicB   = 1'($urandom);
      invertIn = 1'($urandom);
      padIn    = 1'($urandom);
      padMode  = ($urandom_range(0, 7) == 0);
      modeSel  = 3'($urandom);
      clkLines = 4'($urandom);
      clkSel   = 2'($urandom);
      srLines  = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'd0;
      setSel   = 2'($urandom);
      rstSel   = 2'($urandom);
      stepCheck("");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule